// File: doc/BRIEF.md
# Two-Dimensional Tile Read Cache

This block is a read-only cache for image texels. It is keyed by square tiles of the image rather than by linear address. A client presents an integer texel coordinate and receives the 32-bit texel together with a flag that tells whether the tile was already resident. When the tile is missing, the block fetches the complete tile from a backing memory port, one texel per beat. It then answers the pending request from the freshly written storage.

Each of the four entries holds one 32x32 tile. Any tile may occupy any entry, and entries are replaced in a fixed rotating order. Because lines are two-dimensional, a vertical neighbour hits just as readily as a horizontal one. Image width and height are inputs, and a coordinate beyond the image edge is pulled back onto the last column or row. Two running counters record hits and misses so that a hit rate can be measured.

Top module: `tile2d_cache`

## Requirements
- R1: A texel (x, y) belongs to the tile keyed by (x div 32, y div 32) and sits at row-major offset (y mod 32)*32 + (x mod 32) in that tile. The returned `rsp_data` is the backing memory's texel at the (clamped) coordinate.
- R2: A request that hits is answered with `rsp_valid`=1 and `rsp_hit`=1 exactly one cycle after it is accepted.
- R3: The first access to a tile misses. The block issues 1024 fetch beats covering that tile in row-major order on `fill_x`/`fill_y`, writes the returned beats, and then answers with `rsp_hit`=0. This takes more than 1024 cycles.
- R4: A read of a horizontal or vertical neighbour hits when it stays in the same tile. A step from y mod 32 = 31 to the next row misses.
- R5: The cache is fully associative with 4 entries, so any four distinct tiles can be resident at once.
- R6: Replacement is round-robin over entries 0,1,2,3,0,… in miss order, regardless of which entries were hit.
- R7: A coordinate with x >= `img_w` is treated as x = `img_w`-1, and y >= `img_h` as y = `img_h`-1.
- R8: While a fill or its response is pending, `req_ready` is 0 and `req_valid` is ignored: it produces no response and changes no counter.
- R9: `hit_count` and `miss_count` each increase by one for every accepted request that hits or misses, respectively.
- R10: After reset, every entry is invalid, both counters are 0, `req_ready` is 1, and `rsp_valid` and `fill_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| img_w | input | 12 | Image width in texels (at least 1) |
| img_h | input | 12 | Image height in texels (at least 1) |
| req_valid | input | 1 | Read request present |
| req_x | input | 12 | Requested texel column |
| req_y | input | 12 | Requested texel row |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned texel |
| rsp_hit | output | 1 | Response was served without a fill |
| fill_req | output | 1 | Fetch beat request to backing memory |
| fill_x | output | 12 | Column of the texel being fetched |
| fill_y | output | 12 | Row of the texel being fetched |
| fill_valid | input | 1 | Returned beat present |
| fill_data | input | 32 | Returned texel data, in issue order |
| hit_count | output | 32 | Number of accepted hits |
| miss_count | output | 32 | Number of accepted misses |

## Verification
A hit answers one cycle after acceptance. The bench therefore counts falling edges from the accepting edge and requires the strobe at the first one. A miss answers only after all 1024 beats have come back through the fixed-latency memory model, so the bench polls for the strobe with a cycle count and requires that count to exceed 1024. Flags and data are sampled at the falling edge on which the strobe is seen. Counters are read in idle cycles after the response, and the stall check samples `req_ready` on every falling edge of a running fill.

// File: rtl/tile2d_cache_pkg.sv
// Shared types for the 2D tile read cache.
package tile2d_cache_pkg;
    // Controller phases: waiting, fetching a tile, answering after a fill.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_READ = 2'd2
    } cache_state_t;
endpackage

// File: rtl/tc_tag_match.sv
// Fully associative tile-tag lookup.
// Compares a tile key against every resident entry in parallel and reports
// the lowest matching way. Assumes at most one valid entry holds any key.
module tc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 7,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_x_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_y_i,
    input  logic [TAG_W-1:0]            look_x,
    input  logic [TAG_W-1:0]            look_y,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            hit_way_o
);
    logic [WAYS-1:0] match;

    // One comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign match[g] = valid_i[g] && (tag_x_i[g] == look_x) && (tag_y_i[g] == look_y);
    end

    assign hit_o = |match;

    // Encode the matching way.
    always_comb begin
        hit_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tc_fill_seq.sv
// Tile fill sequencer.
// On start, issues one fetch per texel of a tile in row-major order, then
// counts returned beats. Assumes the memory returns beats in issue order.
module tc_fill_seq #(
    parameter int TILE_LOG2 = 5,
    localparam int OFF_W = 2 * TILE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             beat_valid,
    output logic             issue_on,
    output logic [OFF_W-1:0] issue_idx,
    output logic [OFF_W-1:0] rcv_idx,
    output logic             rcv_last
);
    localparam logic [OFF_W-1:0] LAST = '1;

    // Issue and receive counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_on  <= 1'b0;
            issue_idx <= '0;
            rcv_idx   <= '0;
        end else if (start) begin
            issue_on  <= 1'b1;
            issue_idx <= '0;
            rcv_idx   <= '0;
        end else begin
            if (issue_on) begin
                issue_idx <= issue_idx + 1'b1;
                if (issue_idx == LAST) issue_on <= 1'b0;
            end
            if (beat_valid) rcv_idx <= rcv_idx + 1'b1;
        end
    end

    assign rcv_last = beat_valid && (rcv_idx == LAST);
endmodule

// File: rtl/tc_data_store.sv
// Texel storage for all ways: one write port, one registered read port.
// Assumes the caller never reads and writes the same word in one cycle.
module tc_data_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write returned beats.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tile2d_cache.sv
// Read-only 2D tile cache: top level.
// Clamps the request coordinate to the image, looks up its tile key, and
// answers hits one cycle later. On a miss, it fetches the whole tile into
// the round-robin victim, then answers. Assumes img_w and img_h are at
// least 1 and are stable while requests are in flight.
module tile2d_cache
    import tile2d_cache_pkg::*;
#(
    parameter int COORD_W   = 12,
    parameter int TEXEL_W   = 32,
    parameter int TILE_LOG2 = 5,
    parameter int WAYS      = 4,
    parameter int CNT_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] img_w,
    input  logic [COORD_W-1:0] img_h,
    input  logic               req_valid,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [TEXEL_W-1:0] rsp_data,
    output logic               rsp_hit,
    output logic               fill_req,
    output logic [COORD_W-1:0] fill_x,
    output logic [COORD_W-1:0] fill_y,
    input  logic               fill_valid,
    input  logic [TEXEL_W-1:0] fill_data,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count
);
    localparam int OFF_W  = 2 * TILE_LOG2;
    localparam int TAG_W  = COORD_W - TILE_LOG2;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int ADDR_W = WAY_W + OFF_W;

    cache_state_t state;

    logic [WAYS-1:0]            valid_q;
    logic [WAYS-1:0][TAG_W-1:0] tag_x_q;
    logic [WAYS-1:0][TAG_W-1:0] tag_y_q;
    logic [WAY_W-1:0]           rr_q;
    logic [WAY_W-1:0]           pend_way;
    logic [OFF_W-1:0]           pend_off;
    logic [TAG_W-1:0]           pend_tx;
    logic [TAG_W-1:0]           pend_ty;

    logic [COORD_W-1:0] cx, cy;
    logic [OFF_W-1:0]   look_off;
    logic               look_hit;
    logic [WAY_W-1:0]   look_way;
    logic               accept;
    logic               start_fill;
    logic               rcv_last;
    logic [OFF_W-1:0]   issue_idx;
    logic [OFF_W-1:0]   rcv_idx;
    logic               store_re;
    logic [ADDR_W-1:0]  store_raddr;

    // Pull out-of-image coordinates onto the last column and row.
    always_comb begin
        cx = (req_x >= img_w) ? img_w - 1'b1 : req_x;
        cy = (req_y >= img_h) ? img_h - 1'b1 : req_y;
    end

    assign look_off   = {cy[TILE_LOG2-1:0], cx[TILE_LOG2-1:0]};
    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign start_fill = accept && !look_hit;

    tc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .valid_i   (valid_q),
        .tag_x_i   (tag_x_q),
        .tag_y_i   (tag_y_q),
        .look_x    (cx[COORD_W-1:TILE_LOG2]),
        .look_y    (cy[COORD_W-1:TILE_LOG2]),
        .hit_o     (look_hit),
        .hit_way_o (look_way)
    );

    tc_fill_seq #(.TILE_LOG2(TILE_LOG2)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_fill),
        .beat_valid (fill_valid && (state == ST_FILL)),
        .issue_on   (fill_req),
        .issue_idx  (issue_idx),
        .rcv_idx    (rcv_idx),
        .rcv_last   (rcv_last)
    );

    assign fill_x = {pend_tx, issue_idx[TILE_LOG2-1:0]};
    assign fill_y = {pend_ty, issue_idx[OFF_W-1:TILE_LOG2]};

    // Choose the read port source: a hit lookup or the post-fill answer.
    always_comb begin
        store_re    = (accept && look_hit) || (state == ST_READ);
        store_raddr = (state == ST_READ) ? {pend_way, pend_off} : {look_way, look_off};
    end

    tc_data_store #(.ADDR_W(ADDR_W), .DATA_W(TEXEL_W)) u_store (
        .clk   (clk),
        .we    (fill_valid && (state == ST_FILL)),
        .waddr ({pend_way, rcv_idx}),
        .wdata (fill_data),
        .re    (store_re),
        .raddr (store_raddr),
        .rdata (rsp_data)
    );

    // Control: lookup, victim choice, fill tracking, response and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            valid_q    <= '0;
            tag_x_q    <= '0;
            tag_y_q    <= '0;
            rr_q       <= '0;
            pend_way   <= '0;
            pend_off   <= '0;
            pend_tx    <= '0;
            pend_ty    <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept && look_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        hit_count <= hit_count + 1'b1;
                    end else if (accept) begin
                        miss_count     <= miss_count + 1'b1;
                        valid_q[rr_q]  <= 1'b0;
                        tag_x_q[rr_q]  <= cx[COORD_W-1:TILE_LOG2];
                        tag_y_q[rr_q]  <= cy[COORD_W-1:TILE_LOG2];
                        pend_tx        <= cx[COORD_W-1:TILE_LOG2];
                        pend_ty        <= cy[COORD_W-1:TILE_LOG2];
                        pend_way       <= rr_q;
                        pend_off       <= look_off;
                        state          <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (rcv_last) state <= ST_READ;
                end
                ST_READ: begin
                    rsp_valid         <= 1'b1;
                    rsp_hit           <= 1'b0;
                    valid_q[pend_way] <= 1'b1;
                    rr_q              <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
                    state             <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tile2d_cache_chk.sv
// Port-level protocol checker for tile2d_cache, bound to every instance.
module tile2d_cache_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             fill_req,
    input logic             fill_valid,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_valid && req_ready) |-> rsp_hit);  // R2
    AST_MISS_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> $past(!req_ready));  // R3
    AST_BUSY_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req || fill_valid) |-> !req_ready);  // R8
    AST_HIT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> hit_count == $past(hit_count) + 1'b1);  // R9
    AST_MISS_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> miss_count == $past(miss_count) + 1'b1);  // R9
    AST_HIT_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count != $past(hit_count) |-> hit_count == $past(hit_count) + 1'b1);  // R9
endmodule

bind tile2d_cache tile2d_cache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .fill_req   (fill_req),
    .fill_valid (fill_valid),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/sim_tile2d_cache.sv
// Self-checking bench for tile2d_cache with a fixed-latency texel memory.
module sim_tile2d_cache;
    localparam int LAT = 4;
    localparam int IMG_W = 100;
    localparam int IMG_H = 80;
    localparam int NVEC = 16;

    // Row: {x[11:0], y[11:0], expected hit}
    localparam logic [24:0] VEC [NVEC] = '{
        {12'd5,   12'd5,  1'b0},   // R3 cold miss, tile (0,0) -> way0
        {12'd6,   12'd5,  1'b1},   // R4 horizontal neighbour
        {12'd5,   12'd6,  1'b1},   // R4 vertical neighbour
        {12'd5,   12'd31, 1'b1},   // R4 last row of tile
        {12'd31,  12'd31, 1'b1},   // R1 far corner
        {12'd5,   12'd32, 1'b0},   // R4 crossing y mod 32 = 31 -> way1
        {12'd32,  12'd0,  1'b0},   // R5 tile (1,0) -> way2
        {12'd40,  12'd40, 1'b0},   // R5 tile (1,1) -> way3
        {12'd0,   12'd0,  1'b1},   // R5 four tiles resident
        {12'd70,  12'd10, 1'b0},   // R6 evicts way0 (0,0) despite recent hit
        {12'd0,   12'd0,  1'b0},   // R6 (0,0) gone, evicts way1 (0,1)
        {12'd33,  12'd1,  1'b1},   // R6 (1,0) still resident
        {12'd5,   12'd40, 1'b0},   // R6 (0,1) gone, evicts way2 (1,0)
        {12'd33,  12'd1,  1'b0},   // R6 (1,0) gone, evicts way3
        {12'd200, 12'd10, 1'b0},   // R7 clamps to (99,10), tile (3,0)
        {12'd99,  12'd10, 1'b1}    // R7 same texel now hits
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] img_w = 12'(IMG_W);
    logic [11:0] img_h = 12'(IMG_H);
    logic        req_valid = 1'b0;
    logic [11:0] req_x = '0, req_y = '0;
    logic        req_ready, rsp_valid, rsp_hit, fill_req;
    logic [31:0] rsp_data;
    logic [11:0] fill_x, fill_y;
    logic        fill_valid;
    logic [31:0] fill_data;
    logic [31:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    int exp_hits = 0;
    int exp_miss = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    tile2d_cache u0 (
        .clk(clk), .rst_n(rst_n), .img_w(img_w), .img_h(img_h),
        .req_valid(req_valid), .req_x(req_x), .req_y(req_y), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
        .fill_req(fill_req), .fill_x(fill_x), .fill_y(fill_y),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] texel(logic [11:0] x, logic [11:0] y);
        return {8'hC3, y, x};
    endfunction

    // Fixed-latency backing memory.
    logic [LAT-1:0] pv;
    logic [31:0]    pd [LAT];
    always_ff @(posedge clk) begin
        pv[0] <= fill_req;
        pd[0] <= texel(fill_x, fill_y);
        for (int i = 1; i < LAT; i++) begin
            pv[i] <= pv[i-1];
            pd[i] <= pd[i-1];
        end
    end
    assign fill_valid = pv[LAT-1];
    assign fill_data  = pd[LAT-1];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    // Drive one request and wait for its response; returns cycles to response.
    task automatic do_read(input logic [11:0] x, input logic [11:0] y, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_x = x; req_y = y;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [11:0] clampv(logic [11:0] v, int lim);
        return (int'(v) >= lim) ? 12'(lim - 1) : v;
    endfunction

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 req_ready", 32'(req_ready), 32'd1);
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 fill_req", 32'(fill_req), 32'd0);
        chk("R10 hit_count", hit_count, 32'd0);
        chk("R10 miss_count", miss_count, 32'd0);
        rst_n = 1'b1;

        // Vector table walk (R1..R7)
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] vx, vy;
            logic        vh;
            {vx, vy, vh} = VEC[i];
            do_read(vx, vy, lat);
            chk($sformatf("R1 data row %0d", i), rsp_data,
                texel(clampv(vx, IMG_W), clampv(vy, IMG_H)));
            chk($sformatf("R4/R6 hit flag row %0d", i), 32'(rsp_hit), 32'(vh));
            if (vh) begin
                exp_hits++;
                chk($sformatf("R2 hit latency row %0d", i), 32'(lat), 32'd1);
            end else begin
                exp_miss++;
                chk($sformatf("R3 miss latency>1024 row %0d", i), 32'(lat > 1024), 32'd1);
            end
        end
        @(negedge clk);
        chk("R9 hit_count", hit_count, 32'(exp_hits));
        chk("R9 miss_count", miss_count, 32'(exp_miss));

        // R8: requests during a fill are ignored
        begin
            int stalled = 0;
            int early = 0;
            @(negedge clk);
            req_valid = 1'b1; req_x = 12'd70; req_y = 12'd70;
            @(negedge clk);
            req_x = 12'd99; req_y = 12'd10;   // resident tile, would hit
            for (int k = 0; k < 20; k++) begin
                if (req_ready) stalled++;
                if (rsp_valid) early++;
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk("R8 req_ready low during fill", 32'(stalled), 32'd0);
            chk("R8 no response to stalled request", 32'(early), 32'd0);
            lat = 0;
            while (!rsp_valid && lat < 5000) begin
                @(negedge clk);
                lat++;
            end
            chk("R8 fill response data", rsp_data, texel(12'd70, 12'd70));
            chk("R8 fill response flag", 32'(rsp_hit), 32'd0);
            exp_miss++;
            @(negedge clk);
            chk("R8 stalled request not counted hit", hit_count, 32'(exp_hits));
            chk("R8 miss count", miss_count, 32'(exp_miss));
        end

        // R10: reset invalidates entries and clears counters
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 hit_count after reset", hit_count, 32'd0);
        chk("R10 miss_count after reset", miss_count, 32'd0);
        chk("R10 req_ready after reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        do_read(12'd99, 12'd10, lat);
        chk("R10 entries invalid after reset", 32'(rsp_hit), 32'd0);
        chk("R10 data after refill", rsp_data, texel(12'd99, 12'd10));

        // R7: vertical clamp
        do_read(12'd10, 12'd300, lat);
        chk("R7 y clamp data", rsp_data, texel(12'd10, 12'(IMG_H - 1)));

        finish_run();
    end
endmodule